// File: doc/BRIEF.md
# Edge-Interval Signal Validity Checker

This block decides whether a demodulated serial line carries a real transmitter signal or only noise. After receiver start-up has settled, a start strobe arms it. It then times every gap between successive transitions of the data line, in sample-clock ticks, against a window set by a lower and an upper limit. A transition counts whether it rises or falls. The coding is assumed to have two transitions per data bit, as in Manchester or bi-phase, so each bit costs two interval checks.

A 2-bit selector sets how many bits must be seen in a row, so the check either succeeds fast or rejects noise more firmly. When enough consecutive gaps fall inside the window, the block pulses its pass output to request receive mode. When a single gap falls outside the window, it pulses its fail output at once to request sleep mode. A gap also fails if the line stays quiet for too long. After either pulse the block goes idle and waits for the next strobe.

Top module: `edge_window_qualifier`

## Requirements
- R1: A synchronous reset returns the block to idle, from any point in a run, with both outputs low. No pulse follows until a new start strobe arrives.
- R2: A start strobe is acted on only while idle. The selector is captured at that strobe. A strobe, or a selector change, during a running check has no effect on the outcome.
- R3: The data line passes through a two-flop synchronizer. A transition of either polarity counts as an edge. The first edge after the strobe only starts the timer and is not checked. Until that edge arrives, the block waits without any timeout.
- R4: An interval is the number of clock ticks d between two edges seen at the synchronizer output. The interval is valid when lowLimit <= d < highLimit, and the valid range includes both end values lowLimit and highLimit-1.
- R5: An interval with d < lowLimit ends the run with a fail pulse.
- R6: An interval with d >= highLimit ends the run with a fail pulse. If no edge arrives by the time the interval count reaches highLimit, the run fails at that point. The interval counter saturates and never wraps.
- R7: Selector values 1, 2 and 3 require 6, 12 and 18 consecutive valid intervals (3, 6 and 9 bits). The pass pulse fires after the last required interval and not before it.
- R8: Selector value 0 requires no intervals. The pass pulse is high in the cycle right after the clock edge that samples the strobe.
- R9: Pass and fail are each one cycle long and are never high together. Each run produces exactly one of them, and the block is idle in the cycle the pulse is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| startStrobe | input | 1 | Starts a check when idle |
| dataIn | input | 1 | Demodulated data line, asynchronous |
| lowLimit | input | CNT_W | Shortest valid interval in ticks |
| highLimit | input | CNT_W | First interval length that is too long |
| bitSel | input | 2 | Bit count select: 0, 3, 6 or 9 bits |
| passPulse | output | 1 | One-cycle request for receive mode |
| failPulse | output | 1 | One-cycle request for sleep mode |

## Verification
Two events can land in the same cycle. One is an edge whose interval is exactly highLimit. The other is the quiet-line timeout, which also triggers when the counter reaches highLimit. The bench provokes this overlap by spacing two edges exactly highLimit ticks apart. It judges the result by seeing exactly one fail pulse and no pass pulse, so neither event may produce a second outcome or a valid count. A second overlap is a start strobe with selector 0 issued while a run is measuring. The bench checks that no pass appears in the following cycle and that the original run still finishes with a single pass.

// File: rtl/ewq_pkg.sv
package ewq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARM     = 2'd1,
    ST_MEASURE = 2'd2
  } ewqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchTarget;
    logic clearChecks;
    logic restartTimer;
    logic countCheck;
  } ewqCtrl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic edgeSeen;
    logic tooShort;
    logic tooLong;
    logic lastCheck;
    logic zeroTarget;
  } ewqStat_t;

endpackage

// File: rtl/ewq_datapath.sv
module ewq_datapath
  import ewq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int CHK_W       = 5,
  parameter int STEP_CHECKS = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dataIn,
  input  logic [CNT_W-1:0] lowLimit,
  input  logic [CNT_W-1:0] highLimit,
  input  logic [1:0]       bitSel,
  input  ewqCtrl_t         ctrl,
  output ewqStat_t         stat
);

  localparam logic [CNT_W-1:0] TICK_MAX  = '1;
  localparam logic [CNT_W-1:0] TICK_ONE  = CNT_W'(1);
  localparam logic [CHK_W-1:0] CHK_ONE   = CHK_W'(1);
  localparam logic [CHK_W-1:0] CHK_STEP  = CHK_W'(STEP_CHECKS);

  // input synchronizer chain plus one stage of history
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lineLast;
  logic                   lineNow;

  assign lineNow = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      syncChain <= '0;
      lineLast  <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], dataIn};
      lineLast  <= lineNow;
    end
  end

  // interval timer, saturating
  logic [CNT_W-1:0] tickCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tickCnt <= '0;
    end else if (ctrl.restartTimer) begin
      tickCnt <= TICK_ONE;
    end else if (tickCnt != TICK_MAX) begin
      tickCnt <= tickCnt + TICK_ONE;
    end
  end

  // required check count, captured at start
  logic [CHK_W-1:0] checkTarget;
  logic [CHK_W-1:0] checksDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      checkTarget <= '0;
    end else if (ctrl.latchTarget) begin
      checkTarget <= CHK_W'(bitSel) * CHK_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.clearChecks) begin
      checksDone <= '0;
    end else if (ctrl.countCheck) begin
      checksDone <= checksDone + CHK_ONE;
    end
  end

  always_comb begin
    stat.edgeSeen   = lineNow ^ lineLast;
    stat.tooShort   = tickCnt < lowLimit;
    stat.tooLong    = tickCnt >= highLimit;
    stat.lastCheck  = (checksDone + CHK_ONE) == checkTarget;
    stat.zeroTarget = bitSel == 2'd0;
  end

endmodule

// File: rtl/ewq_control.sv
module ewq_control
  import ewq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startStrobe,
  input  ewqStat_t  stat,
  output ewqCtrl_t  ctrl,
  output logic      passPulse,
  output logic      failPulse,
  output ewqState_e runPhase
);

  ewqState_e state;
  ewqState_e nextState;
  logic      passNext;
  logic      failNext;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    passNext  = 1'b0;
    failNext  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startStrobe) begin
          ctrl.latchTarget = 1'b1;
          ctrl.clearChecks = 1'b1;
          if (stat.zeroTarget) begin
            passNext = 1'b1;
          end else begin
            nextState = ST_ARM;
          end
        end
      end
      ST_ARM: begin
        if (stat.edgeSeen) begin
          ctrl.restartTimer = 1'b1;
          nextState         = ST_MEASURE;
        end
      end
      ST_MEASURE: begin
        if (stat.edgeSeen) begin
          if (stat.tooShort || stat.tooLong) begin
            failNext  = 1'b1;
            nextState = ST_IDLE;
          end else if (stat.lastCheck) begin
            ctrl.countCheck = 1'b1;
            passNext        = 1'b1;
            nextState       = ST_IDLE;
          end else begin
            ctrl.countCheck   = 1'b1;
            ctrl.restartTimer = 1'b1;
          end
        end else if (stat.tooLong) begin
          failNext  = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      passPulse <= 1'b0;
      failPulse <= 1'b0;
    end else begin
      state     <= nextState;
      passPulse <= passNext;
      failPulse <= failNext;
    end
  end

  assign runPhase = state;

endmodule

// File: rtl/edge_window_qualifier.sv
module edge_window_qualifier
  import ewq_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int BITS_PER_STEP = 3,
  parameter int EDGES_PER_BIT = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startStrobe,
  input  logic             dataIn,
  input  logic [CNT_W-1:0] lowLimit,
  input  logic [CNT_W-1:0] highLimit,
  input  logic [1:0]       bitSel,
  output logic             passPulse,
  output logic             failPulse
);

  localparam int STEP_CHECKS = BITS_PER_STEP * EDGES_PER_BIT;
  localparam int MAX_CHECKS  = 3 * STEP_CHECKS;
  localparam int CHK_W       = $clog2(MAX_CHECKS + 1);

  ewqCtrl_t  ctrl;
  ewqStat_t  stat;
  ewqState_e runPhase;

  ewq_datapath #(
    .CNT_W      (CNT_W),
    .CHK_W      (CHK_W),
    .STEP_CHECKS(STEP_CHECKS),
    .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk      (clk),
    .rst      (rst),
    .dataIn   (dataIn),
    .lowLimit (lowLimit),
    .highLimit(highLimit),
    .bitSel   (bitSel),
    .ctrl     (ctrl),
    .stat     (stat)
  );

  ewq_control control_i (
    .clk        (clk),
    .rst        (rst),
    .startStrobe(startStrobe),
    .stat       (stat),
    .ctrl       (ctrl),
    .passPulse  (passPulse),
    .failPulse  (failPulse),
    .runPhase   (runPhase)
  );

endmodule

// File: rtl/ewq_checker.sv
module ewq_checker
  import ewq_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      startStrobe,
  input logic [1:0] bitSel,
  input logic      passPulse,
  input logic      failPulse,
  input ewqState_e runPhase,
  input logic      edgeSeen,
  input logic      tooShort,
  input logic      tooLong
);

  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    !(passPulse && failPulse));

  assert_pass_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    passPulse |=> !passPulse);

  assert_fail_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    failPulse |=> !failPulse);

  assert_idle_at_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    (passPulse || failPulse) |-> runPhase == ST_IDLE);

  assert_zero_bits_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (runPhase == ST_IDLE && startStrobe && bitSel == 2'd0) |=> passPulse);

  assert_short_fails_R5: assert property (@(posedge clk) disable iff (rst)
    (runPhase == ST_MEASURE && edgeSeen && tooShort) |=> failPulse);

  assert_long_fails_R6: assert property (@(posedge clk) disable iff (rst)
    (runPhase == ST_MEASURE && tooLong) |=> failPulse);

  assert_arm_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (runPhase == ST_ARM) |=> (!passPulse && !failPulse));

  assert_pass_origin_R7: assert property (@(posedge clk) disable iff (rst)
    passPulse |-> $past(runPhase == ST_MEASURE ||
                        (runPhase == ST_IDLE && startStrobe && bitSel == 2'd0)));

endmodule

bind edge_window_qualifier ewq_checker checker_i (
  .clk        (clk),
  .rst        (rst),
  .startStrobe(startStrobe),
  .bitSel     (bitSel),
  .passPulse  (passPulse),
  .failPulse  (failPulse),
  .runPhase   (runPhase),
  .edgeSeen   (stat.edgeSeen),
  .tooShort   (stat.tooShort),
  .tooLong    (stat.tooLong)
);

// File: tb/edge_window_qualifier_tb_top.sv
`timescale 1ns/1ps
module edge_window_qualifier_tb_top;

  localparam int CNT_W = 8;
  localparam int LOW   = 8;
  localparam int HIGH  = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             startStrobe = 1'b0;
  logic             dataIn = 1'b0;
  logic [CNT_W-1:0] lowLimit = CNT_W'(LOW);
  logic [CNT_W-1:0] highLimit = CNT_W'(HIGH);
  logic [1:0]       bitSel = 2'd0;
  logic             passPulse;
  logic             failPulse;

  int checks = 0;
  int failures = 0;
  int passSeen = 0;
  int failSeen = 0;
  bit done = 1'b0;

  edge_window_qualifier #(.CNT_W(CNT_W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .startStrobe(startStrobe),
    .dataIn     (dataIn),
    .lowLimit   (lowLimit),
    .highLimit  (highLimit),
    .bitSel     (bitSel),
    .passPulse  (passPulse),
    .failPulse  (failPulse)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (passPulse) passSeen++;
      if (failPulse) failSeen++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startRun(input int sel);
    @(negedge clk);
    bitSel = 2'(sel);
    startStrobe = 1'b1;
    @(negedge clk);
    startStrobe = 1'b0;
  endtask

  task automatic edgeNow();
    dataIn = ~dataIn;
  endtask

  task automatic edgeAfter(input int d);
    repeat (d) @(negedge clk);
    dataIn = ~dataIn;
  endtask

  task automatic expectCounts(input string req, input int p0, input int f0,
                              input int expP, input int expF);
    check(passSeen - p0 == expP, {req, " pass count"}, passSeen - p0, expP);
    check(failSeen - f0 == expF, {req, " fail count"}, failSeen - f0, expF);
  endtask

  // R1: reset state
  task automatic t_reset();
    quiet(3);
    check(passPulse == 1'b0, "R1 pass low after reset", int'(passPulse), 0);
    check(failPulse == 1'b0, "R1 fail low after reset", int'(failPulse), 0);
    quiet(20);
    expectCounts("R1 idle no pulse", 0, 0, 0, 0);
  endtask

  // R8: zero bits passes at once
  task automatic t_zeroBits();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(0);
    check(passPulse == 1'b1, "R8 pass right after strobe", int'(passPulse), 1);
    check(failPulse == 1'b0, "R8 no fail", int'(failPulse), 0);
    @(negedge clk);
    check(passPulse == 1'b0, "R9 pass one cycle", int'(passPulse), 0);
    quiet(10);
    expectCounts("R8 R9 zero bits", p0, f0, 1, 0);
  endtask

  // R7 R3: six intervals, first edge not counted
  task automatic t_sixChecks();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(1);
    edgeNow();
    for (int i = 0; i < 5; i++) edgeAfter(10);
    quiet(9);
    check(passSeen == p0, "R3 R7 no pass before sixth interval", passSeen - p0, 0);
    dataIn = ~dataIn;
    quiet(8);
    expectCounts("R7 six intervals", p0, f0, 1, 0);
  endtask

  // R4: window boundaries, selector 2
  task automatic t_boundaries();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(2);
    edgeNow();
    for (int i = 0; i < 12; i++) edgeAfter((i % 2 == 0) ? LOW : HIGH - 1);
    quiet(10);
    expectCounts("R4 edges at lowLimit and highLimit-1", p0, f0, 1, 0);
  endtask

  // R7: eighteen intervals
  task automatic t_eighteen();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(3);
    edgeNow();
    for (int i = 0; i < 17; i++) edgeAfter(12);
    quiet(9);
    check(passSeen == p0, "R7 no pass after 17 intervals", passSeen - p0, 0);
    dataIn = ~dataIn;
    quiet(8);
    expectCounts("R7 eighteen intervals", p0, f0, 1, 0);
  endtask

  // R5: short interval
  task automatic t_short();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(1);
    edgeNow();
    edgeAfter(10);
    edgeAfter(10);
    edgeAfter(LOW - 1);
    quiet(8);
    expectCounts("R5 interval lowLimit-1", p0, f0, 0, 1);
  endtask

  // R6: interval equal to highLimit, coincides with timeout
  task automatic t_long();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(2);
    edgeNow();
    edgeAfter(11);
    edgeAfter(HIGH);
    quiet(30);
    expectCounts("R6 interval highLimit", p0, f0, 0, 1);
  endtask

  // R6: quiet line after first edge
  task automatic t_timeout();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(1);
    edgeNow();
    quiet(HIGH + 8);
    expectCounts("R6 timeout", p0, f0, 0, 1);
  endtask

  // R3: no timeout before first edge; R1: reset ends the wait
  task automatic t_armWait();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(1);
    quiet(300);
    expectCounts("R3 waiting for first edge", p0, f0, 0, 0);
    rst = 1'b1;
    quiet(2);
    rst = 1'b0;
    quiet(4);
  endtask

  // R1: reset mid measurement
  task automatic t_resetMid();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(1);
    edgeNow();
    edgeAfter(10);
    quiet(3);
    rst = 1'b1;
    quiet(2);
    rst = 1'b0;
    quiet(60);
    expectCounts("R1 reset mid run", p0, f0, 0, 0);
  endtask

  // R2: strobe and selector change during a run are ignored
  task automatic t_ignoreStrobe();
    int p0 = passSeen;
    int f0 = failSeen;
    startRun(1);
    edgeNow();
    edgeAfter(10);
    edgeAfter(10);
    quiet(3);
    startStrobe = 1'b1;
    bitSel = 2'd0;
    @(negedge clk);
    startStrobe = 1'b0;
    check(passPulse == 1'b0, "R2 strobe mid run no pass", int'(passPulse), 0);
    quiet(6);
    dataIn = ~dataIn;
    for (int i = 0; i < 3; i++) edgeAfter(10);
    quiet(8);
    expectCounts("R2 run continues with captured selector", p0, f0, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    quiet(4);
    rst = 1'b0;
    t_reset();
    t_zeroBits();
    quiet(6);
    t_sixChecks();
    quiet(6);
    t_boundaries();
    quiet(6);
    t_eighteen();
    quiet(6);
    t_short();
    quiet(6);
    t_long();
    quiet(6);
    t_timeout();
    quiet(6);
    t_armWait();
    t_resetMid();
    quiet(6);
    t_ignoreStrobe();
    quiet(6);
    t_zeroBits();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule